// File: doc/BRIEF.md
# Error Code Queue with Overflow Marker

This block keeps the numeric error codes an instrument raises until software reads them. Each code is a signed 16-bit value. Codes are pushed as errors happen. Reads return them oldest first, and each read removes the code it returns. A single flag reports whether any code is waiting. That flag is meant to drive bit 2 of the instrument's status byte.

The queue never stalls a producer and never drops a burst of errors without a trace. If a code arrives while every slot is taken, the newest stored code is replaced by the queue-overflow code, -350. Software then sees, at the end of the queue, that codes were lost. A synchronous clear empties the queue in one cycle.

The head code is visible at the read port at all times, so a read takes the value shown in that same cycle. When the queue is empty, the read port shows 0, which means no error.

Top module: `errq_core`

## Requirements
- R1: Codes leave the queue in the order they were pushed.
- R2: A read (`pop_i` high on a non-empty queue) returns the code on `code_o` in that cycle and removes it, so the next code appears after the clock edge.
- R3: A push that arrives while the queue holds DEPTH codes, with no read in the same cycle, replaces the newest stored code with -350 (16'hFEA2); the number of stored codes stays at DEPTH.
- R4: Further pushes while the queue stays full leave the -350 marker and all older codes unchanged.
- R5: `status_err_o` (status byte bit 2) is high exactly when at least one code is stored, updated one edge after the push, read or clear that changes it.
- R6: While the queue is empty, `code_o` shows 0, and a read has no effect: a later push is returned as the head.
- R7: A push and a read in the same cycle on a full queue serve the read first and store the pushed code normally, with no overflow marker.
- R8: `clr_i` high at a clock edge empties the queue by the next cycle, whatever else is requested in that cycle.
- R9: A push and a read in the same cycle on an empty queue store the pushed code and ignore the read.
- R10: After reset, the queue is empty, `status_err_o` is 0 and `code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the whole queue |
| push_i | input | 1 | Store `code_i` this cycle |
| code_i | input | 16 | Signed error code to store |
| pop_i | input | 1 | Take and remove the head code this cycle |
| code_o | output | 16 | Current head code, 0 when empty |
| status_err_o | output | 1 | Queue is non-empty (status byte bit 2) |

## Verification
`code_o` is a combinational view of the head slot, so the value a read takes is due in the same cycle the read is asserted, before the edge that removes it. The bench drives inputs on the falling edge and samples `code_o` 1 ns later, ahead of the rising edge. `status_err_o` and the stored contents change at the rising edge, so their effect is checked at the following falling edge. Overflow and clear are each judged after exactly one edge by draining the queue and comparing every code returned in order.

// File: rtl/errq_pkg.sv
package errq_pkg;
  localparam int CODE_W = 16;
  typedef logic signed [CODE_W-1:0] err_code_t;

  // Marker written into the newest slot when the queue overflows.
  localparam err_code_t OVF_CODE = -16'sd350;
  // Value shown while nothing is stored.
  localparam err_code_t NO_ERR   = '0;

  // Circular pointer step forward for any depth.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Circular pointer step backward for any depth.
  function automatic int unsigned ring_prev(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction
endpackage

// File: rtl/errq_ctrl.sv
module errq_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic          wr_marker,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          pop_done,
  output logic          ovf_hit
);
  import errq_pkg::*;

  logic [AW-1:0] head_q, tail_q, last_slot;
  logic          full, push_done;

  assign empty     = (level == '0);
  assign full      = (level == LW'(DEPTH));
  assign pop_done  = pop & ~empty & ~clr;
  assign push_done = push & ~clr & (~full | pop_done);
  assign ovf_hit   = push & ~clr & full & ~pop_done;
  assign last_slot = AW'(ring_prev(int'(tail_q), DEPTH));

  assign wr_en     = push_done | ovf_hit;
  assign wr_marker = ovf_hit;
  assign wr_addr   = ovf_hit ? last_slot : tail_q;
  assign rd_addr   = head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      level  <= '0;
    end else if (clr) begin
      head_q <= '0;
      tail_q <= '0;
      level  <= '0;
    end else begin
      if (pop_done)  head_q <= AW'(ring_next(int'(head_q), DEPTH));
      if (push_done) tail_q <= AW'(ring_next(int'(tail_q), DEPTH));
      case ({push_done, pop_done})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/errq_store.sv
module errq_store #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  errq_pkg::err_code_t wr_data,
  input  logic [AW-1:0]       rd_addr,
  output errq_pkg::err_code_t rd_data
);
  errq_pkg::err_code_t slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_addr] <= wr_data;
  end

  assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/errq_core.sv
module errq_core #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        push_i,
  input  logic [15:0] code_i,
  input  logic        pop_i,
  output logic [15:0] code_o,
  output logic        status_err_o
);
  import errq_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic          wr_en, wr_marker, empty, pop_done, ovf_hit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [LW-1:0] level;
  err_code_t     wr_data, head_code;

  errq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_i),
    .push     (push_i),
    .pop      (pop_i),
    .wr_en    (wr_en),
    .wr_marker(wr_marker),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .level    (level),
    .empty    (empty),
    .pop_done (pop_done),
    .ovf_hit  (ovf_hit)
  );

  assign wr_data = wr_marker ? OVF_CODE : err_code_t'(code_i);

  errq_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(head_code)
  );

  assign code_o       = empty ? NO_ERR : head_code;
  assign status_err_o = ~empty;
endmodule

// File: rtl/errq_chk.sv
module errq_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic          push_i,
  input logic          pop_i,
  input logic [15:0]   code_o,
  input logic          status_err_o,
  input logic [LW-1:0] level,
  input logic          ovf_hit,
  input logic          pop_done
);
  AST_EMPTY_SHOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !status_err_o |-> code_o == 16'h0000); // R6

  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !push_i && pop_i && !status_err_o) |=> (!status_err_o && level == '0)); // R6

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!status_err_o && level == '0)); // R8

  AST_OVF_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> level == LW'(DEPTH)); // R3

  AST_FULL_RW_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && push_i && pop_i && level == LW'(DEPTH)) |-> (!ovf_hit && pop_done)); // R7

  AST_PUSH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && push_i && !pop_i) |=> status_err_o); // R5

  AST_BOTH_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && push_i && pop_i && !status_err_o) |=> level == LW'(1)); // R9
endmodule

bind errq_core errq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .code_o      (code_o),
  .status_err_o(status_err_o),
  .level       (level),
  .ovf_hit     (ovf_hit),
  .pop_done    (pop_done)
);

// File: tb/errq_core_bench.sv
`timescale 1ns/100ps
module errq_core_bench;
  localparam int DEPTH = 8;
  localparam logic [15:0] MARK = 16'hFEA2; // -350

  typedef struct packed {
    logic        push;
    logic        pop;
    logic [15:0] din;
    logic [15:0] exp_head; // code_o before the edge
    logic        exp_ne;   // status_err_o after the edge
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b0, 16'h0011, 16'h0000, 1'b1},
    '{1'b1, 1'b0, 16'h0022, 16'h0011, 1'b1},
    '{1'b0, 1'b1, 16'h0000, 16'h0011, 1'b1},
    '{1'b0, 1'b1, 16'h0000, 16'h0022, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0},
    '{1'b1, 1'b1, 16'h0033, 16'h0000, 1'b1},
    '{1'b0, 1'b1, 16'h0000, 16'h0033, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, push = 1'b0, pop = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic ne;
  int total = 0, bad = 0;
  logic [15:0] seen;
  bit done = 0;

  always #2.5 clk = ~clk;

  errq_core #(.DEPTH(DEPTH)) u_errq_core (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .push_i(push), .code_i(din),
    .pop_i(pop), .code_o(dout), .status_err_o(ne)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, sample head, take one rising edge.
  task automatic cyc(input logic p, input logic q, input logic [15:0] d, input logic c,
                     output logic [15:0] head);
    push = p; pop = q; din = d; clr = c;
    #1 head = dout;
    @(posedge clk);
    @(negedge clk);
    push = 0; pop = 0; clr = 0; din = '0;
  endtask

  task automatic fill(input logic [15:0] base);
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, base + 16'(i), 0, seen);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 flag in reset", {15'b0, ne}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 flag after reset", {15'b0, ne}, 16'h0000);
    chk("R10 code after reset", dout, 16'h0000);

    // Table: R1 order, R2 read removes, R5 flag, R6 empty read, R9 push+pop on empty
    for (int v = 0; v < 7; v++) begin
      cyc(VECS[v].push, VECS[v].pop, VECS[v].din, 0, seen);
      chk($sformatf("R1/R2/R6/R9 head vector %0d", v), seen, VECS[v].exp_head);
      chk($sformatf("R5 flag vector %0d", v), {15'b0, ne}, {15'b0, VECS[v].exp_ne});
    end

    // R3/R4: overflow marks the newest slot and repeats leave it alone
    fill(16'h0100);
    cyc(1, 0, 16'h0999, 0, seen);
    cyc(1, 0, 16'h0998, 0, seen);
    cyc(1, 0, 16'h0997, 0, seen);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 1, 16'h0, 0, seen);
      if (i < DEPTH - 1) chk("R4 older codes kept", seen, 16'h0100 + 16'(i));
      else               chk("R3 overflow marker", seen, MARK);
    end
    chk("R5 flag after drain", {15'b0, ne}, 16'h0000);

    // R7: push and read together on a full queue
    fill(16'h0200);
    cyc(1, 1, 16'h0AAA, 0, seen);
    chk("R7 read served", seen, 16'h0200);
    for (int i = 1; i <= DEPTH; i++) begin
      cyc(0, 1, 16'h0, 0, seen);
      chk("R7 push stored", seen, (i < DEPTH) ? 16'h0200 + 16'(i) : 16'h0AAA);
    end

    // R6: read on empty then push, pointer untouched
    cyc(0, 1, 16'h0, 0, seen);
    chk("R6 empty read zero", seen, 16'h0000);
    cyc(1, 0, 16'h0444, 0, seen);
    chk("R6 head after empty read", dout, 16'h0444);

    // R8: clear with a push in the same cycle
    cyc(1, 0, 16'h0555, 0, seen);
    cyc(1, 1, 16'h0666, 1, seen);
    chk("R8 flag cleared", {15'b0, ne}, 16'h0000);
    chk("R8 code cleared", dout, 16'h0000);
    cyc(1, 0, 16'h0777, 0, seen);
    chk("R8 push after clear", dout, 16'h0777);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule